// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block manages a shared endpoint buffer memory that is split into fixed-size units. An occupancy bitmap records which units are taken. An allocation request gives an endpoint's maximum packet size and a slot count. The block works out the region the endpoint needs, places it at the lowest free run of units that fits, marks the run as used, and returns the region's byte address and its size in bytes. A free request gives back an address and size that an allocation returned earlier, and the block clears exactly those units.

A chip holds one instance for the transmit buffer space and one for the receive buffer space. The base byte address and the number of usable bitmap bits are configuration inputs. Requests come in one at a time over a valid/ready handshake. Each accepted request produces a one-cycle response on the next clock.

Top module: `fifo_seg_alloc`

## Requirements
- R1: During and after reset, with no request taken yet, `req_ready` is 1, `rsp_valid` is 0, and every unit is free. A first allocation therefore lands at `cfg_base`.
- R2: The segment size is `req_maxp` rounded up to the next power of two. A `req_maxp` of 0 or 1 gives a segment of 1 byte.
- R3: For an allocation (`req_free` = 0), the region size is (`req_slot` + 1) times the segment size and is returned on `rsp_size`. The region takes ceil(region / UNIT_BYTES) units.
- R4: An allocation is placed at the lowest start unit s such that units s up to s+n-1 are all free and s+n does not exceed the effective limit. The block then marks those units as used.
- R5: A successful allocation returns `rsp_addr` = `cfg_base` + s × UNIT_BYTES with `rsp_err` = 0, so the address is always whole units from the base.
- R6: When no run fits, the response has `rsp_err` = 1, `rsp_addr` = 0 and `rsp_size` = 0, and the bitmap stays unchanged.
- R7: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `rsp_valid` is high for exactly the following cycle, and `req_ready` is 0 while `rsp_valid` is high.
- R8: A free request (`req_free` = 1) clears ceil(`req_size` / UNIT_BYTES) units starting at unit (`req_addr` − `cfg_base`) / UNIT_BYTES. Its response echoes `req_addr` and `req_size` with `rsp_err` = 0.
- R9: A free request is refused with `rsp_err` = 1 and no change to the bitmap when any of these holds: `req_addr` is below `cfg_base`, the offset is not a whole number of units, `req_size` is 0, or the run reaches past MAP_BITS.
- R10: A `cfg_limit` above MAP_BITS acts as MAP_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Byte address of unit 0 |
| cfg_limit | input | LIM_W | Number of bitmap units allocations may use |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_free | input | 1 | 0 = allocate, 1 = free |
| req_maxp | input | MAXP_W | Maximum packet size in bytes (allocate) |
| req_slot | input | SLOT_W | Extra slots beyond the first (allocate) |
| req_addr | input | ADDR_W | Region address to release (free) |
| req_size | input | SIZE_W | Region size in bytes to release (free) |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_err | output | 1 | Request refused |
| rsp_addr | output | ADDR_W | Allocated or echoed address |
| rsp_size | output | SIZE_W | Allocated or echoed size in bytes |

## Verification
The bench builds the block with a 32-unit bitmap, 512-byte units, an 11-bit packet size and a 3-bit slot count, and places the base at 0x1000. With the small map, a single request can ask for the whole memory, so both exhausting the bitmap and fully rebuilding it take only a few operations. The width of `cfg_limit` can express values above the map size, which makes clamping testable. Placement is exercised through holes that earlier frees leave behind, and through a request that is too large for the first hole and has to skip it.

// File: rtl/fifo_seg_alloc_pkg.sv
package fifo_seg_alloc_pkg;
   typedef enum logic {
      OP_ALLOC = 1'b0,
      OP_FREE  = 1'b1
   } seg_op_e;
endpackage

// File: rtl/fifo_seg_size.sv
module fifo_seg_size #(
   parameter int MAXP_W  = 11,
   parameter int SLOT_W  = 3,
   parameter int UNIT_LG = 9,
   localparam int SEG_W  = MAXP_W + 1,
   localparam int SIZE_W = SEG_W + SLOT_W
) (
   input  logic [MAXP_W-1:0] maxp,
   input  logic [SLOT_W-1:0] slot,
   output logic [SIZE_W-1:0] region_bytes,
   output logic [SIZE_W-1:0] units
);
   localparam logic [SIZE_W:0] UNIT_M1 = (SIZE_W+1)'((1 << UNIT_LG) - 1);

   logic [SEG_W-1:0]  seg;
   logic [SIZE_W:0]   rounded;

   always_comb begin
      seg = SEG_W'(1);
      for (int i = 0; i < MAXP_W; i++) begin
         if ((SEG_W'(1) << i) < SEG_W'(maxp)) seg = SEG_W'(1) << (i + 1);
      end
   end

   assign region_bytes = SIZE_W'(seg) * (SIZE_W'(slot) + SIZE_W'(1));
   assign rounded      = ({1'b0, region_bytes} + UNIT_M1) >> UNIT_LG;
   assign units        = rounded[SIZE_W-1:0];
endmodule

// File: rtl/fifo_first_fit.sv
module fifo_first_fit #(
   parameter int MAP_BITS = 128,
   parameter int CNT_W    = 15,
   parameter int LIM_W    = 8,
   localparam int IDX_W   = (MAP_BITS > 1) ? $clog2(MAP_BITS) : 1
) (
   input  logic [MAP_BITS-1:0] map,
   input  logic [CNT_W-1:0]    units,
   input  logic [LIM_W-1:0]    limit,
   output logic                found,
   output logic [IDX_W-1:0]    start,
   output logic [MAP_BITS-1:0] mask
);
   logic [MAP_BITS-1:0] run_mask;
   logic [MAP_BITS-1:0] fits;

   assign run_mask = ~({MAP_BITS{1'b1}} << units);

   for (genvar s = 0; s < MAP_BITS; s++) begin : g_start
      assign fits[s] = ((map & (run_mask << s)) == '0) &&
                       (({1'b0, units} + (CNT_W+1)'(s)) <= (CNT_W+1)'(limit));
   end

   always_comb begin
      found = 1'b0;
      start = '0;
      for (int i = MAP_BITS - 1; i >= 0; i--) begin
         if (fits[i]) begin
            found = 1'b1;
            start = IDX_W'(i);
         end
      end
   end

   assign mask = found ? (run_mask << start) : '0;
endmodule

// File: rtl/fifo_unit_map.sv
module fifo_unit_map #(
   parameter int MAP_BITS = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [MAP_BITS-1:0] set_mask,
   input  logic [MAP_BITS-1:0] clr_mask,
   output logic [MAP_BITS-1:0] map_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (set_en) begin
         map_q <= map_q | set_mask;
      end else if (clr_en) begin
         map_q <= map_q & ~clr_mask;
      end
   end
endmodule

// File: rtl/fifo_seg_alloc.sv
module fifo_seg_alloc
   import fifo_seg_alloc_pkg::*;
#(
   parameter int UNIT_BYTES = 512,
   parameter int MAP_BITS   = 128,
   parameter int ADDR_W     = 32,
   parameter int MAXP_W     = 11,
   parameter int SLOT_W     = 3,
   localparam int LIM_W     = $clog2(MAP_BITS + 1),
   localparam int SIZE_W    = MAXP_W + 1 + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LIM_W-1:0]  cfg_limit,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_free,
   input  logic [MAXP_W-1:0] req_maxp,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [SIZE_W-1:0] rsp_size
);
   localparam int UNIT_LG = $clog2(UNIT_BYTES);
   localparam int IDX_W   = (MAP_BITS > 1) ? $clog2(MAP_BITS) : 1;
   localparam logic [SIZE_W:0] UNIT_M1 = (SIZE_W+1)'(UNIT_BYTES - 1);

   if ((1 << UNIT_LG) != UNIT_BYTES) begin : g_bad_unit
      $error("UNIT_BYTES must be a power of two");
   end
   if (MAP_BITS < 2) begin : g_bad_map
      $error("MAP_BITS must be at least 2");
   end
   if (ADDR_W < SIZE_W + 1 || SIZE_W <= UNIT_LG) begin : g_bad_width
      $error("ADDR_W or SIZE_W too narrow for the unit size");
   end

   logic                acc;
   logic                is_free;
   logic [SIZE_W-1:0]   a_bytes;
   logic [SIZE_W-1:0]   a_units;
   logic [LIM_W-1:0]    lim_eff;
   logic                fit_ok;
   logic [IDX_W-1:0]    fit_idx;
   logic [MAP_BITS-1:0] fit_mask;
   logic [MAP_BITS-1:0] map_q;

   logic [SIZE_W:0]     f_round;
   logic [SIZE_W-1:0]   f_units;
   logic [ADDR_W-1:0]   f_off;
   logic [ADDR_W-1:0]   f_start;
   logic [ADDR_W:0]     f_span;
   logic                f_err;
   logic [MAP_BITS-1:0] f_mask;

   assign req_ready = !rsp_valid;
   assign acc       = req_valid && req_ready;
   assign is_free   = (seg_op_e'(req_free) == OP_FREE);
   assign lim_eff   = (cfg_limit > LIM_W'(MAP_BITS)) ? LIM_W'(MAP_BITS) : cfg_limit;

   fifo_seg_size #(
      .MAXP_W (MAXP_W),
      .SLOT_W (SLOT_W),
      .UNIT_LG(UNIT_LG)
   ) u_size (
      .maxp        (req_maxp),
      .slot        (req_slot),
      .region_bytes(a_bytes),
      .units       (a_units)
   );

   fifo_first_fit #(
      .MAP_BITS(MAP_BITS),
      .CNT_W   (SIZE_W),
      .LIM_W   (LIM_W)
   ) u_fit (
      .map  (map_q),
      .units(a_units),
      .limit(lim_eff),
      .found(fit_ok),
      .start(fit_idx),
      .mask (fit_mask)
   );

   assign f_round = ({1'b0, req_size} + UNIT_M1) >> UNIT_LG;
   assign f_units = f_round[SIZE_W-1:0];
   assign f_off   = req_addr - cfg_base;
   assign f_start = f_off >> UNIT_LG;
   assign f_span  = {1'b0, f_start} + (ADDR_W+1)'(f_units);
   assign f_err   = (req_addr < cfg_base) || (|f_off[UNIT_LG-1:0]) ||
                    (f_units == '0) || (f_span > (ADDR_W+1)'(MAP_BITS));
   assign f_mask  = (~({MAP_BITS{1'b1}} << f_units)) << f_start;

   fifo_unit_map #(
      .MAP_BITS(MAP_BITS)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (acc && !is_free && fit_ok),
      .clr_en  (acc && is_free && !f_err),
      .set_mask(fit_mask),
      .clr_mask(f_mask),
      .map_q   (map_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
         rsp_size  <= '0;
      end else begin
         rsp_valid <= acc;
         if (acc) begin
            if (is_free) begin
               rsp_err  <= f_err;
               rsp_addr <= req_addr;
               rsp_size <= req_size;
            end else begin
               rsp_err  <= !fit_ok;
               rsp_addr <= fit_ok ? (cfg_base + (ADDR_W'(fit_idx) << UNIT_LG)) : '0;
               rsp_size <= fit_ok ? a_bytes : '0;
            end
         end
      end
   end
endmodule

// File: rtl/fifo_seg_alloc_chk.sv
module fifo_seg_alloc_chk #(
   parameter int UNIT_BYTES = 512,
   parameter int MAP_BITS   = 128,
   parameter int ADDR_W     = 32,
   parameter int MAXP_W     = 11,
   parameter int SLOT_W     = 3,
   localparam int SIZE_W    = MAXP_W + 1 + SLOT_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   cfg_base,
   input logic                req_valid,
   input logic                req_ready,
   input logic                req_free,
   input logic [MAXP_W-1:0]   req_maxp,
   input logic [SLOT_W-1:0]   req_slot,
   input logic                rsp_valid,
   input logic                rsp_err,
   input logic [ADDR_W-1:0]   rsp_addr,
   input logic [SIZE_W-1:0]   rsp_size,
   input logic [MAP_BITS-1:0] map_q
);
   localparam int UNIT_LG = $clog2(UNIT_BYTES);

   logic [ADDR_W-1:0] off_c;
   assign off_c = rsp_addr - cfg_base;

   // R7
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R7
   single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R7
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));

   // R5
   unit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && !$past(req_free)) |-> (off_c[UNIT_LG-1:0] == '0));

   // R3
   region_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && !$past(req_free)) |->
      (rsp_size >= SIZE_W'($past(req_maxp)) * (SIZE_W'($past(req_slot)) + SIZE_W'(1))));

   // R6
   err_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> $stable(map_q));

   // R4
   alloc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && !$past(req_free)) |->
      ($countones(map_q) > $countones($past(map_q))));
endmodule

bind fifo_seg_alloc fifo_seg_alloc_chk #(
   .UNIT_BYTES(UNIT_BYTES),
   .MAP_BITS  (MAP_BITS),
   .ADDR_W    (ADDR_W),
   .MAXP_W    (MAXP_W),
   .SLOT_W    (SLOT_W)
) u_chk (.*);

// File: tb/fifo_seg_alloc_tb.sv
module fifo_seg_alloc_tb_top;
   localparam int UB   = 512;
   localparam int MAPB = 32;
   localparam int AW   = 32;
   localparam int MW   = 11;
   localparam int SW   = 3;
   localparam int LW   = $clog2(MAPB + 1);
   localparam int ZW   = MW + 1 + SW;
   localparam int BASE = 32'h1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = AW'(BASE);
   logic [LW-1:0] cfg_limit = LW'(MAPB);
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_free = 1'b0;
   logic [MW-1:0] req_maxp = '0;
   logic [SW-1:0] req_slot = '0;
   logic [AW-1:0] req_addr = '0;
   logic [ZW-1:0] req_size = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [AW-1:0] rsp_addr;
   logic [ZW-1:0] rsp_size;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;
   bit  mdl [MAPB];
   int  lim   = MAPB;
   int  al_addr [$];
   int  al_size [$];

   always #10 clk = ~clk;

   fifo_seg_alloc #(
      .UNIT_BYTES(UB), .MAP_BITS(MAPB), .ADDR_W(AW), .MAXP_W(MW), .SLOT_W(SW)
   ) dut_i (
      .clk, .rst_n, .cfg_base, .cfg_limit, .req_valid, .req_ready, .req_free,
      .req_maxp, .req_slot, .req_addr, .req_size, .rsp_valid, .rsp_err,
      .rsp_addr, .rsp_size
   );

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_op();
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #5;
      chk("R7 response lasts one cycle", rsp_valid, 0);
      chk("R7 ready returns", req_ready, 1);
   endtask

   task automatic do_alloc(int maxp, int slot, string tag);
      int seg = 1;
      int total, n, es, le;
      bit eerr = 1;
      while (seg < maxp) seg *= 2;
      total = (slot + 1) * seg;
      n  = (total + UB - 1) / UB;
      le = (lim > MAPB) ? MAPB : lim;
      es = 0;
      for (int s = 0; s + n <= le; s++) begin
         bit ok = 1;
         for (int k = 0; k < n; k++) if (mdl[s+k]) ok = 0;
         if (ok) begin es = s; eerr = 0; break; end
      end
      @(negedge clk);
      chk("R7 ready before request", req_ready, 1);
      req_valid = 1'b1; req_free = 1'b0;
      req_maxp = MW'(maxp); req_slot = SW'(slot);
      @(posedge clk); #5;
      chk({tag, " R7 rsp_valid"}, rsp_valid, 1);
      chk({tag, " R6 err"}, rsp_err, eerr);
      chk({tag, " R4 R5 addr"}, rsp_addr, eerr ? 0 : BASE + es * UB);
      chk({tag, " R2 R3 size"}, rsp_size, eerr ? 0 : total);
      if (!eerr) begin
         for (int k = 0; k < n; k++) mdl[es+k] = 1;
         al_addr.push_back(BASE + es * UB);
         al_size.push_back(total);
      end
      finish_op();
   endtask

   task automatic do_free(int addr, int size, string tag);
      int off = addr - BASE;
      int n = (size + UB - 1) / UB;
      bit eerr = (addr < BASE) || (off % UB != 0) || (n == 0) || (off / UB + n > MAPB);
      @(negedge clk);
      req_valid = 1'b1; req_free = 1'b1;
      req_addr = AW'(addr); req_size = ZW'(size);
      @(posedge clk); #5;
      chk({tag, " R7 rsp_valid"}, rsp_valid, 1);
      chk({tag, " R8 R9 err"}, rsp_err, eerr);
      chk({tag, " R8 addr echo"}, rsp_addr, addr);
      chk({tag, " R8 size echo"}, rsp_size, size);
      if (!eerr) for (int k = 0; k < n; k++) mdl[off / UB + k] = 0;
      finish_op();
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MAPB; i++) mdl[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", req_ready, 1);
      chk("R1 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 no response after reset", rsp_valid, 0);

      do_alloc(512, 2, "R1 first at base");       // units 0..2
      do_alloc(1024, 1, "R3 two slots");          // units 3..6
      do_alloc(8, 0, "R2 small packet");          // unit 7
      do_alloc(513, 1, "R2 round up 513");        // units 8..11
      do_alloc(100, 2, "R2 round up 100");        // unit 12
      do_alloc(1, 0, "R2 one byte");              // unit 13
      do_free(BASE + 3 * UB, 2048, "R8 free middle");
      do_alloc(64, 1, "R4 first fit hole");       // unit 3
      do_alloc(1024, 2, "R4 skip small hole");    // units 14..19
      do_free(BASE + 100, 512, "R9 misaligned");
      do_free(BASE - UB, 512, "R9 below base");
      do_free(BASE, 0, "R9 zero size");
      do_free(BASE + 30 * UB, 2048, "R9 past map");
      lim = 21; cfg_limit = LW'(21);
      do_alloc(1024, 3, "R6 no fit in limit");
      do_alloc(512, 0, "R6 map kept");            // unit 4
      lim = 32; cfg_limit = LW'(32);
      do_alloc(1024, 3, "R4 limit raised");       // units 20..27
      do_alloc(2047, 7, "R6 too large");
      while (al_addr.size() > 0) begin
         do_free(al_addr.pop_front(), al_size.pop_front(), "R8 release");
      end
      lim = 63; cfg_limit = LW'(63);
      do_alloc(2047, 7, "R10 clamp whole map");
      do_alloc(1, 0, "R10 map full");

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule